// File: doc/BRIEF.md
# Video Page Write Shadow Bank Selector

This block watches the cycles of a host bus and copies every host write that lands in one of the four video pages into a local RAM with two banks, main and auxiliary. A display engine then reads that RAM at its own pace. For each snooped cycle the block gets the address, the captured data word, a write flag, a device-select flag and a valid strobe. It also gets the host's current memory-switch flags: 80-column store, auxiliary write, second page and high-resolution.

The block picks the target bank with a rule that depends on the video region. In the first text page and the first high-resolution page, the 80-column store flag can override the auxiliary-write flag, and the second-page flag then chooses the bank. In the second text page and the second high-resolution page, only the auxiliary-write flag counts. Reads, device-select cycles and addresses outside the video pages never reach the RAM. The accepted write is issued on a registered port one clock after the strobe.

Top module: `vid_shadow_bank_sel`

## Requirements
- R1: While reset is high and in the first cycle after it, ram_we, ram_aux, ram_addr and ram_data are all 0.
- R2: A write to $0400-$07FF (address bits [15:10] = 1) goes to the bank given by sw_page2 when sw_store80 is 1. When sw_store80 is 0 it goes to the bank given by sw_ramwrt. ram_aux = 1 means the auxiliary bank, 0 the main bank.
- R3: A write to $0800-$0BFF (bits [15:10] = 2) sets ram_aux to sw_ramwrt, whatever the other flags are.
- R4: A write to $2000-$3FFF (bits [15:10] = 8..15) sets ram_aux to sw_page2 only when both sw_store80 and sw_hires are 1. Otherwise it sets ram_aux to sw_ramwrt.
- R5: A write to $4000-$5FFF (bits [15:10] = 16..23) sets ram_aux to sw_ramwrt, whatever the other flags are.
- R6: A cycle with snp_write = 0 (a read) never raises ram_we, even inside a video page.
- R7: A write whose address is outside the four video pages never raises ram_we. Examples are $03FF, $0C00, $1FFF, $6000, $C000 and $FFFF.
- R8: A cycle with snp_devsel = 1 never raises ram_we, even for a write inside a video page.
- R9: An accepted write raises ram_we for exactly one clock, in the cycle after the edge that sampled snp_valid. In that cycle ram_addr equals the snooped 16-bit address and ram_data equals bits [7:0] of snp_data. ram_addr, ram_data and ram_aux keep their values until the next accepted write.
- R10: The switch flags are taken from the same clock edge as the valid strobe. Writes on consecutive cycles each produce their own one-clock RAM write, each with its own bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| snp_valid | input | 1 | A snooped cycle is present this clock |
| snp_addr | input | ADDR_W (16) | Snooped address |
| snp_data | input | CAP_W (16) | Captured data word; only the low byte is stored |
| snp_write | input | 1 | 1 = write cycle, 0 = read cycle |
| snp_devsel | input | 1 | 1 = device-select cycle, never mirrored |
| sw_store80 | input | 1 | 80-column store flag |
| sw_ramwrt | input | 1 | Auxiliary write flag |
| sw_page2 | input | 1 | Second page flag |
| sw_hires | input | 1 | High-resolution flag |
| ram_we | output | 1 | RAM write strobe, one clock per accepted write |
| ram_aux | output | 1 | Bank select: 1 = auxiliary, 0 = main |
| ram_addr | output | ADDR_W (16) | RAM write address |
| ram_data | output | 8 | RAM write byte |

## Verification
Two things can fall in the same cycle. One is issuing the previous write on the RAM port. The other is capturing the next snooped cycle, possibly together with a flip of the switch flags. The bench provokes this with back-to-back writes to the first text page and the first high-resolution page, toggling the 80-column store and second-page flags on exactly the strobe cycle. It then judges, one clock later, that each RAM write carries its own address, byte and bank, where the bank comes from the flags present with its own strobe. Every other region and flag combination is swept with single writes, and the one-cycle pulse and the held address are checked in the cycle after each write.

// File: rtl/vshadow_pkg.sv
package vshadow_pkg;

    localparam int ADDR_BITS  = 16;
    localparam int BYTE_BITS  = 8;
    localparam int PAGE_SHIFT = 10;
    localparam int PAGE_BITS  = ADDR_BITS - PAGE_SHIFT;

    // 1 KB page numbers bounding each video region
    localparam logic [PAGE_BITS-1:0] TXT1_LO = 6'd1;
    localparam logic [PAGE_BITS-1:0] TXT1_HI = 6'd1;
    localparam logic [PAGE_BITS-1:0] TXT2_LO = 6'd2;
    localparam logic [PAGE_BITS-1:0] TXT2_HI = 6'd2;
    localparam logic [PAGE_BITS-1:0] HGR1_LO = 6'd8;
    localparam logic [PAGE_BITS-1:0] HGR1_HI = 6'd15;
    localparam logic [PAGE_BITS-1:0] HGR2_LO = 6'd16;
    localparam logic [PAGE_BITS-1:0] HGR2_HI = 6'd23;

    typedef enum logic [2:0] {
        RGN_NONE  = 3'd0,
        RGN_TEXT1 = 3'd1,
        RGN_TEXT2 = 3'd2,
        RGN_HGR1  = 3'd3,
        RGN_HGR2  = 3'd4
    } region_e;

    typedef struct packed {
        logic store80;
        logic ramwrt;
        logic page2;
        logic hires;
    } sw_flags_t;

    typedef struct packed {
        logic                 we;
        logic                 aux;
        logic [ADDR_BITS-1:0] addr;
        logic [BYTE_BITS-1:0] data;
    } ram_wr_t;

    function automatic logic in_span(input logic [PAGE_BITS-1:0] pg,
                                     input logic [PAGE_BITS-1:0] lo,
                                     input logic [PAGE_BITS-1:0] hi);
        return (pg >= lo) && (pg <= hi);
    endfunction

endpackage

// File: rtl/vsh_region_decode.sv
module vsh_region_decode
    import vshadow_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);
    localparam int PG_W = ADDR_W - PAGE_SHIFT;

    logic [PG_W-1:0] page;
    assign page = addr[ADDR_W-1:PAGE_SHIFT];

    always_comb begin
        region = RGN_NONE;
        if (in_span(page, TXT1_LO, TXT1_HI))      region = RGN_TEXT1;
        else if (in_span(page, TXT2_LO, TXT2_HI)) region = RGN_TEXT2;
        else if (in_span(page, HGR1_LO, HGR1_HI)) region = RGN_HGR1;
        else if (in_span(page, HGR2_LO, HGR2_HI)) region = RGN_HGR2;
    end
endmodule

// File: rtl/vsh_bank_policy.sv
module vsh_bank_policy
    import vshadow_pkg::*;
(
    input  region_e   region,
    input  sw_flags_t flags,
    input  logic      valid,
    input  logic      is_write,
    input  logic      devsel,
    output logic      hit,
    output logic      aux
);
    logic override_txt;
    logic override_hgr;

    // page2 steering only when the store flag (and, for hires, the hires flag) allow it
    assign override_txt = flags.store80;
    assign override_hgr = flags.store80 & flags.hires;

    always_comb begin
        aux = flags.ramwrt;
        unique case (region)
            RGN_TEXT1: aux = override_txt ? flags.page2 : flags.ramwrt;
            RGN_HGR1:  aux = override_hgr ? flags.page2 : flags.ramwrt;
            default:   aux = flags.ramwrt;
        endcase
    end

    assign hit = valid & is_write & ~devsel & (region != RGN_NONE);
endmodule

// File: rtl/vsh_issue_reg.sv
module vsh_issue_reg
    import vshadow_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic              aux,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] data,
    output logic              we_q,
    output logic              aux_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [BYTE_W-1:0] data_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            we_q   <= 1'b0;
            aux_q  <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            we_q <= hit;
            if (hit) begin
                aux_q  <= aux;
                addr_q <= addr;
                data_q <= data;
            end
        end
    end
endmodule

// File: rtl/vid_shadow_bank_sel.sv
module vid_shadow_bank_sel
    import vshadow_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CAP_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [CAP_W-1:0]  snp_data,
    input  logic              snp_write,
    input  logic              snp_devsel,
    input  logic              sw_store80,
    input  logic              sw_ramwrt,
    input  logic              sw_page2,
    input  logic              sw_hires,
    output logic              ram_we,
    output logic              ram_aux,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_data
);
    localparam int BYTE_W = BYTE_BITS;

    region_e   region;
    sw_flags_t flags;
    logic      hit;
    logic      aux_sel;
    logic [BYTE_W-1:0] byte_lo;

    assign flags   = '{store80: sw_store80, ramwrt: sw_ramwrt,
                       page2: sw_page2, hires: sw_hires};
    assign byte_lo = snp_data[BYTE_W-1:0];

    generate
        if (CAP_W > BYTE_W) begin : g_wide
            logic unused_hi;
            assign unused_hi = ^snp_data[CAP_W-1:BYTE_W];
        end
    endgenerate

    vsh_region_decode #(.ADDR_W(ADDR_W)) i_decode (
        .addr   (snp_addr),
        .region (region)
    );

    vsh_bank_policy i_policy (
        .region   (region),
        .flags    (flags),
        .valid    (snp_valid),
        .is_write (snp_write),
        .devsel   (snp_devsel),
        .hit      (hit),
        .aux      (aux_sel)
    );

    vsh_issue_reg #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) i_issue (
        .clk    (clk),
        .rst    (rst),
        .hit    (hit),
        .aux    (aux_sel),
        .addr   (snp_addr),
        .data   (byte_lo),
        .we_q   (ram_we),
        .aux_q  (ram_aux),
        .addr_q (ram_addr),
        .data_q (ram_data)
    );
endmodule

// File: rtl/vsh_checker.sv
module vsh_checker #(
    parameter int ADDR_W = 16,
    parameter int CAP_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              snp_valid,
    input logic [ADDR_W-1:0] snp_addr,
    input logic [CAP_W-1:0]  snp_data,
    input logic              snp_write,
    input logic              snp_devsel,
    input logic              sw_store80,
    input logic              sw_ramwrt,
    input logic              sw_page2,
    input logic              sw_hires,
    input logic              ram_we,
    input logic              ram_aux,
    input logic [ADDR_W-1:0] ram_addr,
    input logic [7:0]        ram_data
);
    logic [ADDR_W-11:0] opage;
    assign opage = ram_addr[ADDR_W-1:10];

    p_read_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && !snp_write) |=> !ram_we);

    p_devsel_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_devsel) |=> !ram_we);

    p_in_region_r7: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (opage == 1 || opage == 2 || (opage >= 8 && opage <= 23)));

    p_we_cause_r9: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> $past(snp_valid && snp_write && !snp_devsel));

    p_addr_byte_r9: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (ram_addr == $past(snp_addr) && ram_data == $past(snp_data[7:0])));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!ram_we && !$past(rst)) |-> ($stable(ram_addr) && $stable(ram_data) && $stable(ram_aux)));

    p_text2_bank_r3: assert property (@(posedge clk) disable iff (rst)
        (ram_we && opage == 2) |-> ram_aux == $past(sw_ramwrt));

    p_hgr2_bank_r5: assert property (@(posedge clk) disable iff (rst)
        (ram_we && opage >= 16 && opage <= 23) |-> ram_aux == $past(sw_ramwrt));

    p_text1_bank_r2: assert property (@(posedge clk) disable iff (rst)
        (ram_we && opage == 1) |->
            ram_aux == ($past(sw_store80) ? $past(sw_page2) : $past(sw_ramwrt)));

    p_hgr1_bank_r4: assert property (@(posedge clk) disable iff (rst)
        (ram_we && opage >= 8 && opage <= 15) |->
            ram_aux == (($past(sw_store80) && $past(sw_hires)) ? $past(sw_page2) : $past(sw_ramwrt)));
endmodule

bind vid_shadow_bank_sel vsh_checker #(.ADDR_W(ADDR_W), .CAP_W(CAP_W)) i_vsh_checker (
    .clk(clk), .rst(rst), .snp_valid(snp_valid), .snp_addr(snp_addr),
    .snp_data(snp_data), .snp_write(snp_write), .snp_devsel(snp_devsel),
    .sw_store80(sw_store80), .sw_ramwrt(sw_ramwrt), .sw_page2(sw_page2),
    .sw_hires(sw_hires), .ram_we(ram_we), .ram_aux(ram_aux),
    .ram_addr(ram_addr), .ram_data(ram_data)
);

// File: tb/test_vid_shadow_bank_sel.sv
module test_vid_shadow_bank_sel;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        snp_valid = 1'b0;
    logic [15:0] snp_addr = '0;
    logic [15:0] snp_data = '0;
    logic        snp_write = 1'b0;
    logic        snp_devsel = 1'b0;
    logic        sw_store80 = 1'b0, sw_ramwrt = 1'b0, sw_page2 = 1'b0, sw_hires = 1'b0;
    logic        ram_we, ram_aux;
    logic [15:0] ram_addr;
    logic [7:0]  ram_data;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vid_shadow_bank_sel i_vid_shadow_bank_sel (
        .clk(clk), .rst(rst), .snp_valid(snp_valid), .snp_addr(snp_addr),
        .snp_data(snp_data), .snp_write(snp_write), .snp_devsel(snp_devsel),
        .sw_store80(sw_store80), .sw_ramwrt(sw_ramwrt), .sw_page2(sw_page2),
        .sw_hires(sw_hires), .ram_we(ram_we), .ram_aux(ram_aux),
        .ram_addr(ram_addr), .ram_data(ram_data)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // bank expected from the requirements; flags = {store80, ramwrt, page2, hires}
    function automatic logic exp_bank(input logic [15:0] a, input logic [3:0] f);
        int pg = int'(a[15:10]);
        if (pg == 1)              return f[3] ? f[1] : f[2];
        if (pg >= 8 && pg <= 15)  return (f[3] && f[0]) ? f[1] : f[2];
        return f[2];
    endfunction

    // drive one cycle at a falling edge; sample at the next falling edge
    task automatic cyc(input logic [15:0] a, input logic [15:0] d, input logic wr,
                       input logic dev, input logic [3:0] f);
        snp_valid = 1'b1; snp_addr = a; snp_data = d; snp_write = wr; snp_devsel = dev;
        {sw_store80, sw_ramwrt, sw_page2, sw_hires} = f;
        @(negedge clk);
        snp_valid = 1'b0; snp_write = 1'b0; snp_devsel = 1'b0;
    endtask

    task automatic expect_write(input string req, input logic [15:0] a,
                                input logic [15:0] d, input logic aux);
        check(req, "ram_we", 32'(ram_we), 32'd1);
        check(req, "ram_aux", 32'(ram_aux), 32'(aux));
        check(req, "ram_addr", 32'(ram_addr), 32'(a));
        check(req, "ram_data", 32'(ram_data), 32'(d[7:0]));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "we in reset", 32'(ram_we), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "we after reset", 32'(ram_we), 0);
        check("R1", "aux after reset", 32'(ram_aux), 0);
        check("R1", "addr after reset", 32'(ram_addr), 0);
        check("R1", "data after reset", 32'(ram_data), 0);
    endtask

    task automatic t_sweep(input string req, input logic [15:0] a);
        for (int f = 0; f < 16; f++) begin
            logic [15:0] d = 16'h5A00 | 16'(f * 7 + 1);
            cyc(a, d, 1'b1, 1'b0, 4'(f));
            expect_write(req, a, d, exp_bank(a, 4'(f)));
        end
    endtask

    task automatic t_reads();
        logic [15:0] held = ram_addr;
        cyc(16'h0410, 16'h0011, 1'b0, 1'b0, 4'b1111);
        check("R6", "we on read", 32'(ram_we), 0);
        cyc(16'h2345, 16'h0022, 1'b0, 1'b0, 4'b0100);
        check("R6", "we on hires read", 32'(ram_we), 0);
        check("R6", "addr untouched by read", 32'(ram_addr), 32'(held));
    endtask

    task automatic t_outside();
        logic [15:0] outs [6] = '{16'h03FF, 16'h0C00, 16'h1FFF, 16'h6000, 16'hC000, 16'hFFFF};
        logic [15:0] held = ram_addr;
        foreach (outs[i]) begin
            cyc(outs[i], 16'h00EE, 1'b1, 1'b0, 4'b0100);
            check("R7", "we outside video pages", 32'(ram_we), 0);
        end
        check("R7", "addr untouched", 32'(ram_addr), 32'(held));
        // inner edges of the regions do write
        cyc(16'h07FF, 16'h0031, 1'b1, 1'b0, 4'b0000); expect_write("R2", 16'h07FF, 16'h0031, 1'b0);
        cyc(16'h0800, 16'h0032, 1'b1, 1'b0, 4'b0100); expect_write("R3", 16'h0800, 16'h0032, 1'b1);
        cyc(16'h3FFF, 16'h0033, 1'b1, 1'b0, 4'b1011); expect_write("R4", 16'h3FFF, 16'h0033, 1'b1);
        cyc(16'h5FFF, 16'h0034, 1'b1, 1'b0, 4'b0000); expect_write("R5", 16'h5FFF, 16'h0034, 1'b0);
    endtask

    task automatic t_devsel();
        logic [15:0] held = ram_addr;
        cyc(16'h0400, 16'h0077, 1'b1, 1'b1, 4'b0100);
        check("R8", "we with devsel", 32'(ram_we), 0);
        cyc(16'h4400, 16'h0078, 1'b1, 1'b1, 4'b0000);
        check("R8", "we with devsel hires", 32'(ram_we), 0);
        check("R8", "addr untouched", 32'(ram_addr), 32'(held));
    endtask

    task automatic t_timing();
        cyc(16'h0A12, 16'hABCD, 1'b1, 1'b0, 4'b0100);
        expect_write("R9", 16'h0A12, 16'hABCD, 1'b1);
        @(negedge clk);
        check("R9", "single pulse", 32'(ram_we), 0);
        check("R9", "addr held", 32'(ram_addr), 32'h0A12);
        check("R9", "data held", 32'(ram_data), 32'hCD);
        check("R9", "bank held", 32'(ram_aux), 1);
    endtask

    task automatic t_same_cycle();
        // write then flip store80/page2 on the very next strobe
        cyc(16'h0500, 16'h0101, 1'b1, 1'b0, 4'b0000);
        expect_write("R10", 16'h0500, 16'h0101, 1'b0);
        cyc(16'h0501, 16'h0102, 1'b1, 1'b0, 4'b1010);
        expect_write("R10", 16'h0501, 16'h0102, 1'b1);
        cyc(16'h2100, 16'h0103, 1'b1, 1'b0, 4'b1011);
        expect_write("R10", 16'h2100, 16'h0103, 1'b1);
        cyc(16'h2101, 16'h0104, 1'b1, 1'b0, 4'b1010);
        expect_write("R10", 16'h2101, 16'h0104, 1'b0);
        @(negedge clk);
        check("R10", "pulse ends", 32'(ram_we), 0);
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < WATCHDOG; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_sweep("R2", 16'h0456);
        t_sweep("R3", 16'h0B21);
        t_sweep("R4", 16'h2ABC);
        t_sweep("R5", 16'h4C0D);
        t_reads();
        t_outside();
        t_devsel();
        t_timing();
        t_same_cycle();
        done = 1'b1;
        report();
    end
endmodule